// File: doc/BRIEF.md
# Read-Modify-Write Bus Sequencer

This block drives the bus for the read-modify-write instruction class of an 8-bit processor with a 16-bit address space. After a start strobe it fetches the opcode and operand bytes at the program counter and forms the effective address in one of six addressing forms. It then reads the old byte, writes that byte back unchanged, and finally writes the result of an external modify function to the same address. The processor issues a bus access in every cycle, so the block also produces the discarded reads that the real sequence contains. Those reads can have side effects on memory-mapped devices.

The surrounding core supplies the program counter, the two index registers and the addressing form, and it holds the index registers stable while an instruction runs. The modify function (shift, rotate, increment and so on) sits outside the block. It sees the old byte on `mod_operand` and returns its result on `mod_result` within the same cycle. A new instruction may be started in the cycle that signals completion, and it then begins with no idle cycle in between.

Top module: `rmw_seq_top`

## Requirements
- R1: After reset, and between instructions, `busy`, `done` and `bus_we` are 0. The idle bus address is the held program counter, which is 0x0000 after reset.
- R2: Mode code 0 (zero page) takes 5 cycles in this order: read the opcode at PC, read the address byte at PC+1, read the old value at {0x00, byte}, write the old value, write the result.
- R3: Mode code 1 (absolute) takes 6 cycles. The low address byte is read at PC+1 and the high byte at PC+2, with 16-bit wrap. `pc_out` advances once per opcode or operand fetch and equals PC+3 in the completion cycle (PC+2 for the two-byte forms).
- R4: Mode code 2 (zero page plus X) takes 6 cycles. After the address byte it does a discarded read at the unindexed {0x00, byte}, and then uses {0x00, (byte+X) mod 256}.
- R5: Mode codes 3 (absolute plus X) and 4 (absolute plus Y) always take 7 cycles. The discarded read uses the full 16-bit sum base+index, with carry into the high byte, and the same address is then read, written back and written.
- R6: Mode code 5 (pre-indexed indirect) takes 8 cycles: discarded read at {0x00, p}, low byte from {0x00, (p+X) mod 256}, high byte from {0x00, (p+X+1) mod 256}, then read, write back, write.
- R7: Mode code 6 (post-indexed indirect) takes 8 cycles: low byte from {0x00, p}, high byte from {0x00, (p+1) mod 256}, discarded read at the 16-bit sum pointer+Y, then read, write back, write.
- R8: The cycle before the final write is a write (`bus_we`=1) of the byte read in the cycle before it, at the same address as the final write.
- R9: The final write carries `mod_result` in the same cycle, `done` is 1 in that cycle only, and `mod_operand` then equals the old byte.
- R10: A start strobe in the completion cycle makes the next cycle the opcode fetch at the new `pc_start`, with no idle cycle.
- R11: A start strobe while an instruction is running, other than in its completion cycle, is ignored: the bus sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (taken when idle or in the completion cycle) |
| mode | input | 3 | Addressing form: 0 zp, 1 abs, 2 zp+X, 3 abs+X, 4 abs+Y, 5 pre-indexed indirect, 6 post-indexed indirect |
| pc_start | input | 16 | Address of the opcode, taken with `start` |
| x_idx | input | 8 | X index register, held during the instruction |
| y_idx | input | 8 | Y index register, held during the instruction |
| bus_addr | output | 16 | Bus address of the current cycle |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, captured at the end of the cycle |
| mod_operand | output | 8 | Old byte handed to the modify function |
| mod_result | input | 8 | Result of the modify function |
| pc_out | output | 16 | Program counter after the fetches so far |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Final write cycle of the instruction |

## Verification
The assertions check the following on every cycle: the write-back of the old byte is always followed by the final write to the same address, the written-back byte equals the byte just read, completion is a single-cycle pulse after 5 to 8 cycles, no write happens while idle, and an accepted start leads to an opcode fetch at the supplied address. Only the bench scenarios show the exact per-cycle address lists of each form. These include zero-page wrap of X indexing and of the pointer high byte, a carry into the high byte for absolute indexing, program counter wrap, back-to-back instructions and an ignored mid-instruction start.

// File: rtl/rmw_seq_pkg.sv
package rmw_seq_pkg;
  typedef enum logic [2:0] {
    MD_ZP   = 3'd0,
    MD_ABS  = 3'd1,
    MD_ZPX  = 3'd2,
    MD_ABSX = 3'd3,
    MD_ABSY = 3'd4,
    MD_IZX  = 3'd5,
    MD_IZY  = 3'd6
  } amode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_OPR1, ST_OPR2, ST_DUMMY,
    ST_PLO, ST_PHI, ST_READ, ST_WOLD, ST_WNEW
  } step_e;
endpackage

// File: rtl/rmw_step_fsm.sv
module rmw_step_fsm
  import rmw_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  amode_e mode_q,
  output step_e  step,
  output logic   accept
);
  step_e nxt;

  assign accept = start && ((step == ST_IDLE) || (step == ST_WNEW));

  always_comb begin
    nxt = step;
    unique case (step)
      ST_IDLE:  if (start) nxt = ST_OPC;
      ST_OPC:   nxt = ST_OPR1;
      ST_OPR1: begin
        unique case (mode_q)
          MD_ABS, MD_ABSX, MD_ABSY: nxt = ST_OPR2;
          MD_ZPX, MD_IZX:           nxt = ST_DUMMY;
          MD_IZY:                   nxt = ST_PLO;
          default:                  nxt = ST_READ;
        endcase
      end
      ST_OPR2:  nxt = (mode_q == MD_ABS) ? ST_READ : ST_DUMMY;
      ST_DUMMY: nxt = (mode_q == MD_IZX) ? ST_PLO : ST_READ;
      ST_PLO:   nxt = ST_PHI;
      ST_PHI:   nxt = (mode_q == MD_IZY) ? ST_DUMMY : ST_READ;
      ST_READ:  nxt = ST_WOLD;
      ST_WOLD:  nxt = ST_WNEW;
      ST_WNEW:  nxt = start ? ST_OPC : ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_IDLE;
    else     step <= nxt;
  end
endmodule

// File: rtl/rmw_addr_path.sv
module rmw_addr_path
  import rmw_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  step_e         step,
  input  logic          accept,
  input  logic [2:0]    mode_in,
  input  logic [AW-1:0] pc_start,
  input  logic [DW-1:0] x_idx,
  input  logic [DW-1:0] y_idx,
  input  logic [DW-1:0] rdata,
  output amode_e        mode_q,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] ea_q,
  output logic [DW-1:0] ptr_q,
  output logic [DW-1:0] val_q
);
  localparam logic [AW-1:0] ONE_A  = AW'(1);
  localparam logic [DW-1:0] ONE_D  = DW'(1);
  localparam logic [DW-1:0] ZERO_D = '0;

  logic [DW-1:0] base_idx;  // index applied when the absolute high byte lands
  logic [DW-1:0] ptr_idx;   // index applied when the indirect high byte lands

  always_comb begin
    base_idx = ZERO_D;
    if (mode_q == MD_ABSX)      base_idx = x_idx;
    else if (mode_q == MD_ABSY) base_idx = y_idx;
  end
  assign ptr_idx = (mode_q == MD_IZY) ? y_idx : ZERO_D;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      ea_q   <= '0;
      ptr_q  <= '0;
      val_q  <= '0;
      mode_q <= MD_ZP;
    end else begin
      if (accept) begin
        pc_q   <= pc_start;
        mode_q <= amode_e'(mode_in);
      end
      unique case (step)
        ST_OPC: pc_q <= pc_q + ONE_A;
        ST_OPR1: begin
          pc_q  <= pc_q + ONE_A;
          ea_q  <= {ZERO_D, rdata};
          ptr_q <= rdata;
        end
        ST_OPR2: begin
          pc_q <= pc_q + ONE_A;
          ea_q <= {rdata, ea_q[DW-1:0]} + {ZERO_D, base_idx};
        end
        ST_DUMMY: begin
          if (mode_q == MD_ZPX) ea_q  <= {ZERO_D, ea_q[DW-1:0] + x_idx};
          if (mode_q == MD_IZX) ptr_q <= ptr_q + x_idx;
        end
        ST_PLO: begin
          ea_q[DW-1:0] <= rdata;
          ptr_q        <= ptr_q + ONE_D;
        end
        ST_PHI:  ea_q  <= {rdata, ea_q[DW-1:0]} + {ZERO_D, ptr_idx};
        ST_READ: val_q <= rdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rmw_bus_drive.sv
module rmw_bus_drive
  import rmw_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  step_e         step,
  input  logic [AW-1:0] pc_q,
  input  logic [AW-1:0] ea_q,
  input  logic [DW-1:0] ptr_q,
  input  logic [DW-1:0] val_q,
  input  logic [DW-1:0] mod_result,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  output logic          done,
  output logic          busy
);
  localparam logic [DW-1:0] ZERO_D = '0;

  always_comb begin
    bus_addr  = pc_q;
    bus_we    = 1'b0;
    bus_wdata = val_q;
    done      = 1'b0;
    unique case (step)
      ST_DUMMY, ST_READ: bus_addr = ea_q;
      ST_PLO, ST_PHI:    bus_addr = {ZERO_D, ptr_q};
      ST_WOLD: begin
        bus_addr = ea_q;
        bus_we   = 1'b1;
      end
      ST_WNEW: begin
        bus_addr  = ea_q;
        bus_we    = 1'b1;
        bus_wdata = mod_result;
        done      = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy = (step != ST_IDLE);
endmodule

// File: rtl/rmw_seq_top.sv
module rmw_seq_top
  import rmw_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [2:0]            mode,
  input  logic [2*DATA_W-1:0]   pc_start,
  input  logic [DATA_W-1:0]     x_idx,
  input  logic [DATA_W-1:0]     y_idx,
  output logic [2*DATA_W-1:0]   bus_addr,
  output logic                  bus_we,
  output logic [DATA_W-1:0]     bus_wdata,
  input  logic [DATA_W-1:0]     bus_rdata,
  output logic [DATA_W-1:0]     mod_operand,
  input  logic [DATA_W-1:0]     mod_result,
  output logic [2*DATA_W-1:0]   pc_out,
  output logic                  busy,
  output logic                  done
);
  localparam int ADDR_W = 2 * DATA_W;

  step_e             step;
  logic              accept;
  amode_e            mode_q;
  logic [ADDR_W-1:0] pc_q, ea_q;
  logic [DATA_W-1:0] ptr_q, val_q;

  rmw_step_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .mode_q(mode_q),
    .step(step), .accept(accept)
  );

  rmw_addr_path #(.DW(DATA_W), .AW(ADDR_W)) u_path (
    .clk(clk), .rst(rst), .step(step), .accept(accept), .mode_in(mode),
    .pc_start(pc_start), .x_idx(x_idx), .y_idx(y_idx), .rdata(bus_rdata),
    .mode_q(mode_q), .pc_q(pc_q), .ea_q(ea_q), .ptr_q(ptr_q), .val_q(val_q)
  );

  rmw_bus_drive #(.DW(DATA_W), .AW(ADDR_W)) u_bus (
    .step(step), .pc_q(pc_q), .ea_q(ea_q), .ptr_q(ptr_q), .val_q(val_q),
    .mod_result(mod_result), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .done(done), .busy(busy)
  );

  assign pc_out      = pc_q;
  assign mod_operand = val_q;
endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [2*DW-1:0] pc_start,
  input logic          busy,
  input logic          done,
  input logic [2*DW-1:0] bus_addr,
  input logic          bus_we,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] mod_operand
);
  logic [3:0] span;  // cycles since the opcode fetch, counting that cycle as 1

  always_ff @(posedge clk) begin
    if (rst) span <= '0;
    else if (start && (!busy || done)) span <= 4'd1;
    else if (busy && span != 4'hF) span <= span + 4'd1;
  end

  AST_WB_THEN_FINAL: assert property (@(posedge clk) disable iff (rst) (bus_we && !done) |=> (bus_we && done)) else $error("write-back not followed by final write"); // R8
  AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (rst) (bus_we && !done) |=> (bus_addr == $past(bus_addr))) else $error("final write address moved"); // R8
  AST_WB_OLD_BYTE: assert property (@(posedge clk) disable iff (rst) (bus_we && !done) |-> (!$past(bus_we) && bus_wdata == $past(bus_rdata))) else $error("write-back byte differs from read"); // R8
  AST_OPERAND_OLD: assert property (@(posedge clk) disable iff (rst) done |-> (mod_operand == $past(bus_wdata))) else $error("modify operand not the old byte"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done) else $error("done longer than one cycle"); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (!bus_we && !done)) else $error("bus activity while idle"); // R1
  AST_START_FETCH: assert property (@(posedge clk) disable iff (rst) (start && (!busy || done)) |=> (!bus_we && bus_addr == $past(pc_start))) else $error("no opcode fetch after start"); // R10
  AST_LENGTH: assert property (@(posedge clk) disable iff (rst) done |-> (span >= 4'd5 && span <= 4'd8)) else $error("instruction length out of range"); // R2
endmodule

bind rmw_seq_top rmw_seq_chk #(.DW(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .pc_start(pc_start), .busy(busy),
  .done(done), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .mod_operand(mod_operand)
);

// File: tb/rmw_seq_top_tb_top.sv
module rmw_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MOD_KEY = 8'h3C;
  localparam logic [2:0] M_ZP = 3'd0, M_ABS = 3'd1, M_ZPX = 3'd2, M_ABSX = 3'd3,
                         M_ABSY = 3'd4, M_IZX = 3'd5, M_IZY = 3'd6;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0]  mode;
  logic [15:0] pc_start, bus_addr, pc_out;
  logic [7:0]  x_idx, y_idx, bus_wdata, bus_rdata, mod_operand, mod_result;
  logic        bus_we, busy, done;

  typedef struct packed {
    logic [15:0] a;
    logic        we;
    logic        dn;
    logic [7:0]  d;
  } cyc_t;

  cyc_t exp_q[$];
  logic [7:0] mem [logic [15:0]];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mod_result = mod_operand ^ MOD_KEY;

  rmw_seq_top dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .pc_start(pc_start),
    .x_idx(x_idx), .y_idx(y_idx), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mod_operand(mod_operand),
    .mod_result(mod_result), .pc_out(pc_out), .busy(busy), .done(done)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h6B;
  endfunction

  function automatic void put(input logic [15:0] a, input logic we, input logic dn, input logic [7:0] d);
    exp_q.push_back({a, we, dn, d});
  endfunction

  // Expected per-cycle bus trace, built from the requirements; returns instruction length in bytes.
  function automatic int build(input logic [2:0] m, input logic [15:0] p, input logic [7:0] x, input logic [7:0] y);
    logic [15:0] ea;
    logic [7:0] b, lo, hi, pt, old;
    int nb;
    exp_q.delete();
    nb = 2;
    put(p, 1'b0, 1'b0, 8'h00);
    b = rd(p + 16'd1);
    put(p + 16'd1, 1'b0, 1'b0, 8'h00);
    ea = {8'h00, b};
    case (m)
      M_ABS, M_ABSX, M_ABSY: begin
        hi = rd(p + 16'd2);
        put(p + 16'd2, 1'b0, 1'b0, 8'h00);
        nb = 3;
        ea = {hi, b};
        if (m == M_ABSX) begin ea = ea + {8'h00, x}; put(ea, 1'b0, 1'b0, 8'h00); end
        else if (m == M_ABSY) begin ea = ea + {8'h00, y}; put(ea, 1'b0, 1'b0, 8'h00); end
      end
      M_ZPX: begin
        put({8'h00, b}, 1'b0, 1'b0, 8'h00);
        pt = b + x;
        ea = {8'h00, pt};
      end
      M_IZX: begin
        put({8'h00, b}, 1'b0, 1'b0, 8'h00);
        pt = b + x;
        lo = rd({8'h00, pt});
        put({8'h00, pt}, 1'b0, 1'b0, 8'h00);
        pt = pt + 8'd1;
        hi = rd({8'h00, pt});
        put({8'h00, pt}, 1'b0, 1'b0, 8'h00);
        ea = {hi, lo};
      end
      M_IZY: begin
        lo = rd({8'h00, b});
        put({8'h00, b}, 1'b0, 1'b0, 8'h00);
        pt = b + 8'd1;
        hi = rd({8'h00, pt});
        put({8'h00, pt}, 1'b0, 1'b0, 8'h00);
        ea = {hi, lo} + {8'h00, y};
        put(ea, 1'b0, 1'b0, 8'h00);
      end
      default: ;
    endcase
    old = rd(ea);
    put(ea, 1'b0, 1'b0, 8'h00);
    put(ea, 1'b1, 1'b0, old);
    put(ea, 1'b1, 1'b1, old ^ MOD_KEY);
    return nb;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge inside the completion cycle.
  task automatic run(input logic [2:0] m, input logic [15:0] p, input logic [7:0] x,
                     input logic [7:0] y, input string tag, input bit poke);
    int nb;
    string rtag;
    logic [25:0] act;
    nb = build(m, p, x, y);
    mode = m; pc_start = p; x_idx = x; y_idx = y; start = 1'b1;
    for (int i = 0; i < exp_q.size(); i++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && i == 2) begin
        start = 1'b1; pc_start = 16'hBEEF; mode = M_IZY;  // R11: must be ignored
      end
      bus_rdata = rd(bus_addr);
      act = {bus_addr, bus_we, done, (bus_we ? bus_wdata : 8'h00)};
      rtag = exp_q[i].dn ? "R9" : (exp_q[i].we ? "R8" : tag);
      if (poke) rtag = "R11";
      chk(act == exp_q[i], rtag, $sformatf("cycle %0d of mode %0d", i, m), 32'(act), 32'(exp_q[i]));
      if (exp_q[i].dn) begin
        chk(pc_out == p + 16'(nb), "R3", "program counter at completion", 32'(pc_out), 32'(p + 16'(nb)));
        chk(mod_operand == exp_q[i-1].d, "R9", "modify operand", 32'(mod_operand), 32'(exp_q[i-1].d));
      end
    end
  endtask

  task automatic idle_gap();
    @(negedge clk);
    bus_rdata = rd(bus_addr);
    chk(!busy && !done && !bus_we, "R1", "idle between instructions",
        {29'd0, busy, done, bus_we}, 32'd0);
  endtask

  initial begin
    mode = 3'd0; pc_start = 16'h0; x_idx = 8'h0; y_idx = 8'h0; bus_rdata = 8'h0;
    mem[16'h1001] = 8'h42; mem[16'h0042] = 8'h99;
    mem[16'h2001] = 8'h34; mem[16'h2002] = 8'h12; mem[16'h1234] = 8'h5A;
    mem[16'h3001] = 8'hF0; mem[16'h0010] = 8'hC3;
    mem[16'h4001] = 8'hF0; mem[16'h4002] = 8'h12; mem[16'h1310] = 8'h77;
    mem[16'h4101] = 8'h00; mem[16'h4102] = 8'h22;
    mem[16'h5001] = 8'hFE; mem[16'h00FF] = 8'h80; mem[16'h0000] = 8'h33; mem[16'h3380] = 8'hE1;
    mem[16'h6001] = 8'hFF;
    mem[16'h7001] = 8'h80; mem[16'h7101] = 8'h01; mem[16'h7102] = 8'h80;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !bus_we, "R1", "flags after reset", {29'd0, busy, done, bus_we}, 32'd0);
    chk(bus_addr == 16'h0000, "R1", "address after reset", 32'(bus_addr), 32'd0);
    run(M_ZP,   16'h1000, 8'h00, 8'h00, "R2", 1'b0); idle_gap();
    run(M_ABS,  16'h2000, 8'h00, 8'h00, "R3", 1'b0); idle_gap();
    run(M_ZPX,  16'h3000, 8'h20, 8'h00, "R4", 1'b0); idle_gap();
    run(M_ABSX, 16'h4000, 8'h20, 8'h00, "R5", 1'b0); idle_gap();
    run(M_ABSY, 16'h4100, 8'h00, 8'h05, "R5", 1'b0); idle_gap();
    run(M_IZX,  16'h5000, 8'h01, 8'h00, "R6", 1'b0); idle_gap();
    run(M_IZY,  16'h6000, 8'h00, 8'h10, "R7", 1'b0); idle_gap();
    run(M_ABS,  16'hFFFF, 8'h00, 8'h00, "R3", 1'b0); idle_gap();
    run(M_ZP,   16'h7000, 8'h00, 8'h00, "R10", 1'b0);
    run(M_ABSX, 16'h7100, 8'hFF, 8'h00, "R10", 1'b0);
    run(M_ZPX,  16'h7200, 8'h01, 8'h00, "R11", 1'b1); idle_gap();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule